// File: doc/BRIEF.md
# Serial Bus Control and Status Register

This block is the control and status register of a clocked serial bus port. Software writes it to frame the bus. One write-one bit drives the serial data-out latch high to signal a bus release, and another drives the latch low to signal a command. Each of these bits acts once and then clears itself. A third write-one bit schedules a single acknowledge bit, which is driven on the next falling edge of the serial clock.

The register also watches the incoming serial lines. Both lines pass through a synchronizer first. A rising data line while the clock is high sets a release flag, and a falling data line while the clock is high sets a command flag. The flags are cleared by bus events that arrive from neighbouring logic: a transfer-start strobe and an address-mismatch result. Byte shifting and address comparison happen elsewhere; only their strobes come in here.

Top module: `sbus_ctl_status`

## Requirements
- R1: After reset the readback is 0x00, the data-out latch is 0 and the acknowledge drive is 0.
- R2: Writing 1 to bit 0 (release request) with the port enabled makes bit 0 read 1 for one cycle. On the following cycle the data-out latch is 1 and bit 0 reads 0.
- R3: Writing 1 to bit 1 (command request) with the port enabled makes bit 1 read 1 for one cycle. On the following cycle the data-out latch is 0 and bit 1 reads 0.
- R4: While the port enable is 0, bits 0, 1, 2, 3 and 4 read 0. Writes to bits 0, 1 and 4 are ignored, the data-out latch holds its value, the acknowledge drive is 0, and line activity sets no flag.
- R5: Bits 6, 3 and 2 ignore writes. Bit 6 always reads 0.
- R6: Bit 2 (release seen) is set within four cycles of the data-in line rising while the serial clock is high. It is cleared by a transfer-start strobe or an address-mismatch strobe.
- R7: Bit 3 (command seen) is set within four cycles of the data-in line falling while the serial clock is high. It is cleared by a transfer-start strobe or by a release detection.
- R8: Writing 1 to bit 4 (acknowledge request) is accepted only if the stored bit 5 is 0. A pending request raises the acknowledge drive at the next synchronized serial-clock fall and clears bit 4. The drive drops at the following fall. A transfer-start strobe cancels a pending request.
- R9: Bits 7 and 5 are plain storage bits. Every write loads them.
- R10: If a clear condition and a detection fall in the same cycle, the clear wins and the flag reads 0.
- R11: If one write sets both bit 0 and bit 1, the release wins and the data-out latch ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register readback |
| sck_in | input | 1 | Serial clock line (asynchronous) |
| sdi_in | input | 1 | Serial data-in line (asynchronous) |
| addr_mismatch | input | 1 | Address mismatch strobe from the address compare |
| xfer_start | input | 1 | Transfer-start strobe |
| so_latch | output | 1 | Serial data-out latch |
| ack_drive | output | 1 | Acknowledge bit drive |

## Verification
Two things can land on the same edge: a synchronized line detection and a strobe that clears the same flag. To provoke this, the bench changes the data line and then raises the transfer-start strobe exactly two clock edges later, so the strobe is sampled on the edge where the detection registers. It does this once for a release and once for a command. Each case is judged by the readback that follows, which must show the flag clear. Two requests written in one word, release plus command, are also provoked, and they are judged by the final data-out latch level.

// File: rtl/sbus_ctl_pkg.sv
// Shared definitions for the serial bus control-status register.
// Assumes an 8-bit register. The field order is fixed because software
// decodes the readback by bit position.
package sbus_ctl_pkg;
    localparam int REG_W = 8;

    // Register image, most significant field first.
    typedef struct packed {
        logic busy_en;    // bit 7: plain storage
        logic ack_seen;   // bit 6: read-only, reads 0
        logic ack_en;     // bit 5: plain storage, blocks ack requests
        logic ack_req;    // bit 4: acknowledge request (self-clearing)
        logic cmd_flag;   // bit 3: command seen (read-only)
        logic rel_flag;   // bit 2: release seen (read-only)
        logic cmd_req;    // bit 1: command request (self-clearing)
        logic rel_req;    // bit 0: release request (self-clearing)
    } sbus_reg_t;
endpackage

// File: rtl/sbus_line_sync.sv
// Synchronizes the serial clock and data lines into the system clock
// domain. From the synchronized lines it flags a release (data rises while
// the clock is high), a command (data falls while the clock is high) and a
// falling edge of the serial clock. The outputs are single-cycle pulses.
// Assumes that both lines idle low during reset.
module sbus_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic sdi_in,
    output logic rel_det,
    output logic cmd_det,
    output logic sck_fall
);
    logic [STAGES-1:0] sck_ff;
    logic [STAGES-1:0] sdi_ff;
    logic              sck_q;
    logic              sdi_q;
    logic              sck_s;
    logic              sdi_s;

    // Synchronizer chain: first stage samples the raw lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_ff[0] <= 1'b0;
            sdi_ff[0] <= 1'b0;
        end else begin
            sck_ff[0] <= sck_in;
            sdi_ff[0] <= sdi_in;
        end
    end

    // Remaining synchronizer stages, one per extra stage.
    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sck_ff[g] <= 1'b0;
                    sdi_ff[g] <= 1'b0;
                end else begin
                    sck_ff[g] <= sck_ff[g-1];
                    sdi_ff[g] <= sdi_ff[g-1];
                end
            end
        end
    endgenerate

    assign sck_s = sck_ff[STAGES-1];
    assign sdi_s = sdi_ff[STAGES-1];

    // Previous-value registers used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            sdi_q <= 1'b0;
        end else begin
            sck_q <= sck_s;
            sdi_q <= sdi_s;
        end
    end

    // Edge decode on the synchronized lines.
    always_comb begin
        rel_det  = sck_s & sdi_s & ~sdi_q;
        cmd_det  = sck_s & ~sdi_s & sdi_q;
        sck_fall = sck_q & ~sck_s;
    end

    // R6/R7: a release and a command can never be flagged together.
    assert_det_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rel_det && cmd_det));
endmodule

// File: rtl/sbus_frame_flags.sv
// Holds the release-seen and command-seen status flags.
// Assumes that the detect inputs are single-cycle pulses. When a clear
// and a set fall in the same cycle, the clear wins.
module sbus_frame_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    input  logic rel_det,
    input  logic cmd_det,
    input  logic xfer_start,
    input  logic addr_mismatch,
    output logic rel_flag,
    output logic cmd_flag
);
    // Release flag: set by a release, cleared by a start or a mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  rel_flag <= 1'b0;
        else if (!port_en || xfer_start || addr_mismatch) rel_flag <= 1'b0;
        else if (rel_det)                            rel_flag <= 1'b1;
    end

    // Command flag: set by a command, cleared by a start or a release.
    always_ff @(posedge clk) begin
        if (!rst_n)                               cmd_flag <= 1'b0;
        else if (!port_en || xfer_start || rel_det) cmd_flag <= 1'b0;
        else if (cmd_det)                         cmd_flag <= 1'b1;
    end

    assert_rel_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start || addr_mismatch) |=> !rel_flag);
    assert_rel_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_det && port_en && !xfer_start && !addr_mismatch) |=> rel_flag);
    assert_cmd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start || rel_det) |=> !cmd_flag);
    assert_flags_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!rel_flag && !cmd_flag));
endmodule

// File: rtl/sbus_ack_sched.sv
// Schedules one acknowledge bit. A request stays pending until the next
// synchronized serial-clock fall. At that fall the drive rises and holds
// for one serial-clock period. Assumes that set_req is already qualified
// by the port enable and by the acknowledge-enable field.
module sbus_ack_sched (
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    input  logic set_req,
    input  logic xfer_start,
    input  logic sck_fall,
    output logic ack_pend,
    output logic ack_drive
);
    // Pending request: cancelled by a start, consumed by a clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n || !port_en)       ack_pend <= 1'b0;
        else if (xfer_start)          ack_pend <= 1'b0;
        else if (set_req)             ack_pend <= 1'b1;
        else if (sck_fall)            ack_pend <= 1'b0;
    end

    // Drive level: updated only on serial-clock falls.
    always_ff @(posedge clk) begin
        if (!rst_n || !port_en)       ack_drive <= 1'b0;
        else if (sck_fall)            ack_drive <= ack_pend & ~xfer_start;
    end

    assert_ack_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && ack_pend && sck_fall && !xfer_start && !set_req)
        |=> (!ack_pend && ack_drive));
    assert_ack_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !ack_pend);
    assert_ack_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !ack_drive);
endmodule

// File: rtl/sbus_ctl_status.sv
// Top of the serial bus control-status register. It holds the writable
// fields and the data-out latch, and it assembles the readback from the
// flag and acknowledge units. Assumes one write per cycle and that the
// strobes are single-cycle pulses in the clk domain.
module sbus_ctl_status
    import sbus_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             sck_in,
    input  logic             sdi_in,
    input  logic             addr_mismatch,
    input  logic             xfer_start,
    output logic             so_latch,
    output logic             ack_drive
);
    sbus_reg_t wr_img;
    sbus_reg_t rd_img;
    logic      busy_en, ack_en, rel_req, cmd_req;
    logic      rel_det, cmd_det, sck_fall;
    logic      rel_flag, cmd_flag, ack_pend;
    logic      ack_set;

    assign wr_img  = sbus_reg_t'(wr_data);
    assign ack_set = port_en & wr_en & wr_img.ack_req & ~ack_en;

    sbus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .sdi_in(sdi_in),
        .rel_det(rel_det), .cmd_det(cmd_det), .sck_fall(sck_fall)
    );

    sbus_frame_flags u_flags (
        .clk(clk), .rst_n(rst_n), .port_en(port_en),
        .rel_det(rel_det), .cmd_det(cmd_det),
        .xfer_start(xfer_start), .addr_mismatch(addr_mismatch),
        .rel_flag(rel_flag), .cmd_flag(cmd_flag)
    );

    sbus_ack_sched u_ack (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .set_req(ack_set),
        .xfer_start(xfer_start), .sck_fall(sck_fall),
        .ack_pend(ack_pend), .ack_drive(ack_drive)
    );

    // Plain storage fields, loaded by every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_en <= 1'b0;
            ack_en  <= 1'b0;
        end else if (wr_en) begin
            busy_en <= wr_img.busy_en;
            ack_en  <= wr_img.ack_en;
        end
    end

    // Self-clearing framing requests, held for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_req <= 1'b0;
            cmd_req <= 1'b0;
        end else begin
            rel_req <= port_en & wr_en & wr_img.rel_req;
            cmd_req <= port_en & wr_en & wr_img.cmd_req;
        end
    end

    // Data-out latch: a release sets it, a command clears it, release first.
    always_ff @(posedge clk) begin
        if (!rst_n)                  so_latch <= 1'b0;
        else if (port_en && rel_req) so_latch <= 1'b1;
        else if (port_en && cmd_req) so_latch <= 1'b0;
    end

    // Readback assembly; bit 6 has no source and reads 0.
    always_comb begin
        rd_img          = '0;
        rd_img.busy_en  = busy_en;
        rd_img.ack_en   = ack_en;
        rd_img.ack_req  = ack_pend;
        rd_img.cmd_flag = cmd_flag;
        rd_img.rel_flag = rel_flag;
        rd_img.cmd_req  = cmd_req;
        rd_img.rel_req  = rel_req;
        rd_data         = rd_img;
    end

    assert_rel_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && !wr_en) |=> !rel_req);
    assert_rel_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && port_en) |=> so_latch);
    assert_cmd_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !rel_req && port_en) |=> !so_latch);
    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> $stable(so_latch));
    assert_ack_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_en && !ack_pend && !xfer_start) |=> !ack_pend);
endmodule

// File: tb/sbus_ctl_status_tb.sv
`timescale 1ns/100ps
module sbus_ctl_status_tb;
    typedef struct {
        string      req;
        logic [7:0] rd;
        logic       so;
        logic       ack;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sck_in = 1'b0;
    logic       sdi_in = 1'b0;
    logic       addr_mismatch = 1'b0;
    logic       xfer_start = 1'b0;
    logic       so_latch;
    logic       ack_drive;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    sbus_ctl_status u_dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .sck_in(sck_in),
        .sdi_in(sdi_in), .addr_mismatch(addr_mismatch),
        .xfer_start(xfer_start), .so_latch(so_latch), .ack_drive(ack_drive)
    );

    // Monitor: pops each expected item and compares it with the ports.
    initial begin
        forever begin
            wait (exp_q.size() > 0);
            begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (rd_data !== e.rd || so_latch !== e.so || ack_drive !== e.ack) begin
                    errors++;
                    $display("FAIL %s: rd=%h so=%b ack=%b expected rd=%h so=%b ack=%b",
                             e.req, rd_data, so_latch, ack_drive, e.rd, e.so, e.ack);
                end
            end
        end
    end

    task automatic expect_out(string req, logic [7:0] rd, logic so, logic ack);
        #0.5;
        exp_q.push_back('{req, rd, so, ack});
        wait (exp_q.size() == 0);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_start();
        @(negedge clk); xfer_start = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
    endtask

    task automatic pulse_mismatch();
        @(negedge clk); addr_mismatch = 1'b1;
        @(negedge clk); addr_mismatch = 1'b0;
    endtask

    task automatic set_sck(logic v);
        @(negedge clk); sck_in = v; step(4);
    endtask

    task automatic set_sdi(logic v);
        @(negedge clk); sdi_in = v; step(4);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Driver: stimulus and expected results.
    initial begin
        step(3);
        expect_out("R1 reset", 8'h00, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b1; port_en = 1'b1;
        step(1);

        write_reg(8'h01); expect_out("R2 release pulse", 8'h01, 1'b0, 1'b0);
        step(1);          expect_out("R2 latch set", 8'h00, 1'b1, 1'b0);
        write_reg(8'h02); expect_out("R3 command pulse", 8'h02, 1'b1, 1'b0);
        step(1);          expect_out("R3 latch clear", 8'h00, 1'b0, 1'b0);
        write_reg(8'h03); expect_out("R11 both pulse", 8'h03, 1'b0, 1'b0);
        step(1);          expect_out("R11 release wins", 8'h00, 1'b1, 1'b0);

        write_reg(8'hAC); expect_out("R5 R9 read-only and storage", 8'hA0, 1'b1, 1'b0);
        write_reg(8'h30); expect_out("R8 ack blocked by stored enable", 8'h20, 1'b1, 1'b0);
        write_reg(8'h10); expect_out("R8 ack blocked, enable cleared", 8'h00, 1'b1, 1'b0);
        write_reg(8'h10); expect_out("R8 ack pending", 8'h10, 1'b1, 1'b0);
        set_sck(1'b1);    expect_out("R8 no drive on rise", 8'h10, 1'b1, 1'b0);
        set_sck(1'b0);    expect_out("R8 drive at fall", 8'h00, 1'b1, 1'b1);
        set_sck(1'b1);
        set_sck(1'b0);    expect_out("R8 drive drops", 8'h00, 1'b1, 1'b0);
        write_reg(8'h10); expect_out("R8 ack pending again", 8'h10, 1'b1, 1'b0);
        pulse_start();    expect_out("R8 start cancels", 8'h00, 1'b1, 1'b0);
        set_sck(1'b1);
        set_sck(1'b0);    expect_out("R8 no drive after cancel", 8'h00, 1'b1, 1'b0);

        set_sck(1'b1);
        set_sdi(1'b1);    expect_out("R6 release seen", 8'h04, 1'b1, 1'b0);
        pulse_start();    expect_out("R6 start clears", 8'h00, 1'b1, 1'b0);
        set_sdi(1'b0);    expect_out("R7 command seen", 8'h08, 1'b1, 1'b0);
        set_sdi(1'b1);    expect_out("R7 release clears command", 8'h04, 1'b1, 1'b0);
        pulse_mismatch(); expect_out("R6 mismatch clears", 8'h00, 1'b1, 1'b0);
        set_sdi(1'b0);    expect_out("R7 command seen again", 8'h08, 1'b1, 1'b0);
        pulse_start();    expect_out("R7 start clears", 8'h00, 1'b1, 1'b0);

        // R10: the strobe is sampled on the edge where the detection registers.
        @(negedge clk); sdi_in = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); xfer_start = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
        step(3);          expect_out("R10 start beats release", 8'h00, 1'b1, 1'b0);
        @(negedge clk); sdi_in = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); xfer_start = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
        step(3);          expect_out("R10 start beats command", 8'h00, 1'b1, 1'b0);

        set_sdi(1'b1);    expect_out("R6 release before disable", 8'h04, 1'b1, 1'b0);
        @(negedge clk); port_en = 1'b0;
        step(1);          expect_out("R4 disable clears flag", 8'h00, 1'b1, 1'b0);
        write_reg(8'h03); expect_out("R4 requests ignored", 8'h00, 1'b1, 1'b0);
        step(1);          expect_out("R4 latch held", 8'h00, 1'b1, 1'b0);
        set_sdi(1'b0);    expect_out("R4 no command flag", 8'h00, 1'b1, 1'b0);
        write_reg(8'h10); expect_out("R4 ack ignored", 8'h00, 1'b1, 1'b0);
        set_sck(1'b0);    expect_out("R4 no ack drive", 8'h00, 1'b1, 1'b0);

        @(negedge clk); port_en = 1'b1;
        write_reg(8'h02); expect_out("R3 command after enable", 8'h02, 1'b1, 1'b0);
        step(1);          expect_out("R3 latch low", 8'h00, 1'b0, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule